// File: doc/BRIEF.md
# AES-256 CBC Block Decryptor

This block turns a stream of 128-bit ciphertext blocks back into plaintext using AES-256 in cipher block chaining mode. One state register is reused for every inverse round, so a block takes one cycle of initial key mixing and then fourteen round cycles. The block never stores or expands the key. Each cycle it puts a round-key index on `rk_idx` and expects the matching 128-bit round key on `rk` in the same cycle. An external key sequencer or a lookup table supplies these keys.

A message begins with `iv_load`, which sets the chaining value. Ciphertext blocks follow on `ct_valid`/`ct`. An accepted block is parked until the next block is accepted. The next block acts as its trigger, so the last real block of a message must be followed by a dummy block. One further block may arrive while rounds are running; it goes into a one-entry buffer, and `busy` tells the source to wait. Each recovered plaintext appears on `pt` with a one-cycle `pt_valid` strobe.

Top module: `aes256_cbc_dec`

## Requirements
- R1: After reset, `pt_valid` is 0, `busy` is 0 and `rk_idx` is 14.
- R2: A single block decrypts to the standard AES-256 inverse cipher result. The key table is indexed by encryption round number. Entries 14 and 0 are the plain expanded round keys. Entries 1 to 13 are the InvMixColumns transform of the expanded keys. Byte 0 of a block sits in bits 127:120, and bytes fill the state column by column.
- R3: Plaintext block i equals the decryption of ciphertext block i XOR ciphertext block i-1, with the loaded IV used in place of block 0.
- R4: An accepted block is not decrypted until another block is accepted. When the engine is idle, `pt_valid` rises 14 clock edges after the edge that accepts that next block.
- R5: `rk_idx` is 14 while the engine is idle, including the cycle in which a trigger is accepted. On the following 14 cycles it steps down from 13 to 0, one step per cycle.
- R6: A block accepted while rounds are in progress is kept in a one-entry buffer, and `busy` is 1 while the buffer is occupied. A `ct_valid` pulse seen while `busy` is 1 is ignored.
- R7: When a buffered block is waiting, the next decryption starts on the cycle after the current one finishes. Consecutive `pt_valid` pulses are then exactly 15 cycles apart.
- R8: `iv_load` is accepted only when the engine is idle and the buffer is empty, and is ignored otherwise. An accepted load drops any parked block. It also takes priority over a `ct_valid` in the same cycle, which is dropped.
- R9: `pt_valid` is a single-cycle pulse, with exactly one pulse per decrypted block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iv_load | input | 1 | Load a new chaining value; starts a new message |
| iv | input | 128 | Initialisation vector |
| ct_valid | input | 1 | Ciphertext block offered |
| ct | input | 128 | Ciphertext block |
| busy | output | 1 | One-entry buffer occupied; hold off input |
| rk_idx | output | 4 | Index of the round key needed this cycle |
| rk | input | 128 | Round key for `rk_idx`, valid in the same cycle |
| pt_valid | output | 1 | Plaintext strobe |
| pt | output | 128 | Plaintext block |

## Verification
The bench drives inputs and samples outputs on the falling edge. Counting from the rising edge that accepts a trigger block into an idle engine, `rk_idx` reads 13 at the next falling edge and then drops by one per cycle. `pt_valid` must be low for 14 falling edges and high at the 15th. The directed latency test checks every one of those intermediate edges rather than waiting for the pulse. `busy` is checked at the first falling edge after a block is accepted mid-decryption. The cycle numbers of successive strobes are recorded so that the 15-cycle spacing of buffered restarts can be compared exactly. Every strobe is matched in order against plaintexts computed by a bench model, with the parked tail block of each message removed from the expected list when a new IV discards it.

// File: rtl/aes_dec_pkg.sv
// aes_dec_pkg: shared widths and GF(2^8) helpers for the inverse AES datapath.
// Assumes the AES field polynomial x^8+x^4+x^3+x+1 and column-major byte order.
package aes_dec_pkg;

    localparam int BLK_W  = 128;
    localparam int COL_W  = 32;
    localparam int BYTE_W = 8;
    localparam int NCOL   = BLK_W / COL_W;
    localparam int NROW   = COL_W / BYTE_W;

    typedef logic [BLK_W-1:0]  blk_t;
    typedef logic [COL_W-1:0]  col_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // Field multiply by shift-and-add.
    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1b : 8'h00);
        end
        return acc;
    endfunction

    // Field inverse as x^254 (zero maps to zero).
    function automatic byte_t gf_inv(input byte_t x);
        byte_t res;
        byte_t pw;
        res = 8'h01;
        pw  = x;
        for (int i = 0; i < BYTE_W; i++) begin
            if (i != 0) res = gf_mul(res, pw);
            pw = gf_mul(pw, pw);
        end
        return res;
    endfunction

    // Inverse S-box: undo the affine map, then invert in the field.
    function automatic byte_t inv_sub(input byte_t s);
        byte_t t;
        t = {s[6:0], s[7]} ^ {s[4:0], s[7:5]} ^ {s[1:0], s[7:2]} ^ 8'h05;
        return gf_inv(t);
    endfunction

    // InvMixColumns on one 32-bit column (top byte is row 0).
    function automatic col_t inv_mix_col(input col_t c);
        byte_t a0, a1, a2, a3;
        a0 = c[31:24]; a1 = c[23:16]; a2 = c[15:8]; a3 = c[7:0];
        return {gf_mul(a0,8'h0e) ^ gf_mul(a1,8'h0b) ^ gf_mul(a2,8'h0d) ^ gf_mul(a3,8'h09),
                gf_mul(a0,8'h09) ^ gf_mul(a1,8'h0e) ^ gf_mul(a2,8'h0b) ^ gf_mul(a3,8'h0d),
                gf_mul(a0,8'h0d) ^ gf_mul(a1,8'h09) ^ gf_mul(a2,8'h0e) ^ gf_mul(a3,8'h0b),
                gf_mul(a0,8'h0b) ^ gf_mul(a1,8'h0d) ^ gf_mul(a2,8'h09) ^ gf_mul(a3,8'h0e)};
    endfunction

endpackage

// File: rtl/aes_inv_round.sv
// aes_inv_round: one combinational inverse round in the equivalent-inverse order
// (InvSubBytes, InvShiftRows, InvMixColumns unless last, then key XOR).
// Assumes middle-round keys arrive already passed through InvMixColumns.
module aes_inv_round
    import aes_dec_pkg::*;
(
    input  blk_t state_i,
    input  blk_t rkey_i,
    input  logic last_i,
    output blk_t state_o
);

    blk_t shuf;

    // Inverse substitution fused with the inverse row rotation.
    for (genvar c = 0; c < NCOL; c++) begin : g_col_sub
        for (genvar r = 0; r < NROW; r++) begin : g_row_sub
            localparam int DST = r + NROW * c;
            localparam int SRC = r + NROW * ((c + NCOL - r) % NCOL);
            assign shuf[BLK_W-1-BYTE_W*DST -: BYTE_W] =
                inv_sub(state_i[BLK_W-1-BYTE_W*SRC -: BYTE_W]);
        end
    end

    // Column mixing (skipped in the final round) followed by the key XOR.
    for (genvar c = 0; c < NCOL; c++) begin : g_col_mix
        col_t raw;
        assign raw = shuf[BLK_W-1-COL_W*c -: COL_W];
        assign state_o[BLK_W-1-COL_W*c -: COL_W] =
            (last_i ? raw : inv_mix_col(raw)) ^ rkey_i[BLK_W-1-COL_W*c -: COL_W];
    end

endmodule

// File: rtl/aes_round_ctrl.sv
// aes_round_ctrl: counts the inverse rounds of one block and names the key
// index needed each cycle. Assumes start_i is raised only while idle.
module aes_round_ctrl #(
    parameter int NR = 14,
    localparam int CW = $clog2(NR + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          run_o,
    output logic          last_o,
    output logic [CW-1:0] rkidx_o
);

    logic [CW-1:0] rnd;

    // Round counter: 1..NR while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_o <= 1'b0;
            rnd   <= '0;
        end else if (start_i) begin
            run_o <= 1'b1;
            rnd   <= CW'(1);
        end else if (run_o) begin
            if (rnd == CW'(NR)) run_o <= 1'b0;
            rnd <= rnd + 1'b1;
        end
    end

    // Key index and last-round flag.
    always_comb begin
        last_o  = run_o && (rnd == CW'(NR));
        rkidx_o = run_o ? (CW'(NR) - rnd) : CW'(NR);
    end

    a_r5_idx_descend: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && !last_o) |=> (rkidx_o == $past(rkidx_o) - 1'b1));

    a_r4_start_round1: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (run_o && rkidx_o == CW'(NR - 1)));

endmodule

// File: rtl/aes_blk_buffer.sv
// aes_blk_buffer: parks the block awaiting its trigger and a one-entry buffer
// for a block that arrives mid-decryption. Assumes clr_i only while idle and empty.
module aes_blk_buffer #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         in_vld_i,
    input  logic [W-1:0] in_dat_i,
    input  logic         idle_i,
    output logic         start_o,
    output logic [W-1:0] blk_o,
    output logic         busy_o
);

    logic [W-1:0] held, queued;
    logic         held_vld, q_vld, acc;

    // Accept and trigger decisions.
    always_comb begin
        acc     = in_vld_i && !q_vld && !clr_i;
        start_o = idle_i && held_vld && (q_vld || acc);
        busy_o  = q_vld;
        blk_o   = held;
    end

    // Parked block and buffer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held     <= '0;
            queued   <= '0;
            held_vld <= 1'b0;
            q_vld    <= 1'b0;
        end else if (clr_i) begin
            held_vld <= 1'b0;
        end else if (start_o) begin
            held  <= q_vld ? queued : in_dat_i;
            q_vld <= 1'b0;
        end else if (acc) begin
            if (!held_vld) begin
                held     <= in_dat_i;
                held_vld <= 1'b1;
            end else begin
                queued <= in_dat_i;
                q_vld  <= 1'b1;
            end
        end
    end

    a_r6_queue_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q_vld && !start_o) |=> (q_vld && $stable(queued)));

endmodule

// File: rtl/aes256_cbc_dec.sv
// aes256_cbc_dec: iterative AES-256 CBC decryptor, one inverse round per cycle.
// Assumes rk carries the key named by rk_idx in the same cycle.
module aes256_cbc_dec
    import aes_dec_pkg::*;
#(
    parameter int NR = 14,
    localparam int KI_W = $clog2(NR + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            iv_load,
    input  logic [127:0]    iv,
    input  logic            ct_valid,
    input  logic [127:0]    ct,
    output logic            busy,
    output logic [KI_W-1:0] rk_idx,
    input  logic [127:0]    rk,
    output logic            pt_valid,
    output logic [127:0]    pt
);

    blk_t state, work, chain, rnd_out, start_blk;
    logic run, last, start, iv_ok;

    assign iv_ok = iv_load && !run && !busy;

    aes_blk_buffer #(.W(BLK_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr_i(iv_ok),
        .in_vld_i(ct_valid), .in_dat_i(ct), .idle_i(!run),
        .start_o(start), .blk_o(start_blk), .busy_o(busy)
    );

    aes_round_ctrl #(.NR(NR)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .run_o(run), .last_o(last), .rkidx_o(rk_idx)
    );

    aes_inv_round u_round (
        .state_i(state), .rkey_i(rk), .last_i(last), .state_o(rnd_out)
    );

    // State register: key whitening on start, one round per running cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= '0;
            work  <= '0;
        end else if (start) begin
            state <= start_blk ^ rk;
            work  <= start_blk;
        end else if (run) begin
            state <= rnd_out;
        end
    end

    // Chaining value: IV on a load, else the finished ciphertext block.
    always_ff @(posedge clk) begin
        if (!rst_n)     chain <= '0;
        else if (iv_ok) chain <= iv;
        else if (last)  chain <= work;
    end

    // Plaintext output and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pt_valid <= 1'b0;
            pt       <= '0;
        end else begin
            pt_valid <= last;
            if (last) pt <= rnd_out ^ chain;
        end
    end

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pt_valid |=> !pt_valid);

    a_r3_chain_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !last) |=> $stable(chain));

endmodule

// File: tb/aes256_cbc_dec_tb_top.sv
// Bench: directed vectors plus seeded random CBC messages against a bench AES model.
module aes256_cbc_dec_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         iv_load = 1'b0;
    logic [127:0] iv = '0;
    logic         ct_valid = 1'b0;
    logic [127:0] ct = '0;
    logic         busy;
    logic [3:0]   rk_idx;
    logic [127:0] rk;
    logic         pt_valid;
    logic [127:0] pt;

    logic [127:0] rk_tab [16];
    logic [127:0] ek [15];
    logic [7:0]   sbt [256];
    logic [127:0] expq [512];
    int           pcyc [512];
    int head = 0, tail = 0, since_iv = 0, cyc = 0, total = 0, bad = 0;
    logic [127:0] chain_m = '0;
    bit done = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign rk = rk_tab[rk_idx];

    aes256_cbc_dec dut_i (
        .clk(clk), .rst_n(rst_n), .iv_load(iv_load), .iv(iv),
        .ct_valid(ct_valid), .ct(ct), .busy(busy), .rk_idx(rk_idx),
        .rk(rk), .pt_valid(pt_valid), .pt(pt)
    );

    function automatic logic [7:0] tmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r, bb;
        r = 0; bb = b;
        for (int i = 0; i < 8; i++) begin
            if (a[i]) r ^= bb;
            bb = (bb << 1) ^ ((bb & 8'h80) != 0 ? 8'h1b : 8'h00);
        end
        return r;
    endfunction

    function automatic logic [31:0] subw(input logic [31:0] w);
        return {sbt[w[31:24]], sbt[w[23:16]], sbt[w[15:8]], sbt[w[7:0]]};
    endfunction

    function automatic logic [31:0] mixf(input logic [31:0] c);
        logic [7:0] a [4];
        logic [31:0] o;
        for (int i = 0; i < 4; i++) a[i] = c[31-8*i -: 8];
        for (int i = 0; i < 4; i++)
            o[31-8*i -: 8] = tmul(a[i], 8'h02) ^ tmul(a[(i+1)%4], 8'h03) ^ a[(i+2)%4] ^ a[(i+3)%4];
        return o;
    endfunction

    function automatic logic [31:0] mixi(input logic [31:0] c);
        logic [7:0] a [4];
        logic [31:0] o;
        for (int i = 0; i < 4; i++) a[i] = c[31-8*i -: 8];
        for (int i = 0; i < 4; i++)
            o[31-8*i -: 8] = tmul(a[i], 8'h0e) ^ tmul(a[(i+1)%4], 8'h0b)
                           ^ tmul(a[(i+2)%4], 8'h0d) ^ tmul(a[(i+3)%4], 8'h09);
        return o;
    endfunction

    function automatic logic [127:0] enc_blk(input logic [127:0] p);
        logic [127:0] s, t;
        s = p ^ ek[0];
        for (int r = 1; r <= 14; r++) begin
            for (int c = 0; c < 4; c++)
                for (int w = 0; w < 4; w++)
                    t[127-8*(w+4*c) -: 8] = sbt[s[127-8*(w+4*((c+w)%4)) -: 8]];
            if (r != 14)
                for (int c = 0; c < 4; c++) t[127-32*c -: 32] = mixf(t[127-32*c -: 32]);
            s = t ^ ek[r];
        end
        return s;
    endfunction

    task automatic build_sbox();
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv, s;
            inv = 0;
            if (x != 0)
                for (int y = 1; y < 256; y++) if (tmul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            s = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^ {inv[4:0], inv[7:5]}
                    ^ {inv[3:0], inv[7:4]} ^ 8'h63;
            sbt[x] = s;
        end
    endtask

    task automatic set_key(input logic [255:0] k);
        logic [31:0] w [60];
        logic [7:0] rc;
        rc = 8'h01;
        for (int i = 0; i < 8; i++) w[i] = k[255-32*i -: 32];
        for (int i = 8; i < 60; i++) begin
            logic [31:0] t;
            t = w[i-1];
            if (i % 8 == 0) begin
                t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
                rc = tmul(rc, 8'h02);
            end else if (i % 8 == 4) begin
                t = subw(t);
            end
            w[i] = w[i-8] ^ t;
        end
        for (int r = 0; r < 15; r++) begin
            ek[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
            if (r == 0 || r == 14) rk_tab[r] = ek[r];
            else rk_tab[r] = {mixi(ek[r][127:96]), mixi(ek[r][95:64]),
                              mixi(ek[r][63:32]), mixi(ek[r][31:0])};
        end
        rk_tab[15] = '0;
    endtask

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s got %h exp %h", req, act, exp);
        end
    endtask

    // Output monitor: every strobe matched in order against the expected list.
    always @(negedge clk) begin
        if (rst_n && pt_valid) begin
            total++;
            if (head >= tail) begin
                bad++;
                $display("FAIL R9 unexpected strobe got %h exp none", pt);
            end else begin
                if (pt !== expq[head]) begin
                    bad++;
                    $display("FAIL R3 block %0d got %h exp %h", head, pt, expq[head]);
                end
                pcyc[head] = cyc;
                head++;
            end
        end
    end

    task automatic send_raw(input logic [127:0] d);
        while (busy) @(negedge clk);
        ct_valid = 1'b1; ct = d;
        @(negedge clk);
        ct_valid = 1'b0;
    endtask

    task automatic send_ct_exp(input logic [127:0] c, input logic [127:0] p);
        expq[tail] = p; tail++; since_iv++; chain_m = c;
        send_raw(c);
    endtask

    task automatic send_pt(input logic [127:0] p);
        send_ct_exp(enc_blk(p ^ chain_m), p);
    endtask

    task automatic wait_drain();
        int n = 0;
        while (head < tail - (since_iv > 0 ? 1 : 0) && n < 400) begin
            @(negedge clk); n++;
        end
        if (n >= 400) chk("R4 drain timeout", 128'(head), 128'(tail - 1));
        @(negedge clk);
    endtask

    // R8: an accepted load drops the parked block, so its expectation goes too.
    task automatic new_msg(input logic [127:0] v);
        if (since_iv > 0) tail--;
        since_iv = 0; chain_m = v;
        iv_load = 1'b1; iv = v;
        @(negedge clk);
        iv_load = 1'b0;
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        int seed_tmp;
        seed_tmp = $urandom(32'd20517);
        build_sbox();
        for (int i = 0; i < 16; i++) rk_tab[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pt_valid after reset", 128'(pt_valid), 128'd0);
        chk("R1 busy after reset", 128'(busy), 128'd0);
        chk("R1 rk_idx after reset", 128'(rk_idx), 128'd14);

        // R2/R4/R5: known-answer block, then trigger and step through rounds.
        set_key(256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f);
        new_msg('0);
        send_ct_exp(128'h8ea2b7ca516745bfeafc49904b496089, 128'h00112233445566778899aabbccddeeff);
        for (int j = 0; j < 6; j++) begin
            chk("R4 no output before trigger", 128'(pt_valid), 128'd0);
            @(negedge clk);
        end
        send_pt(rnd128());
        for (int j = 0; j < 14; j++) begin
            chk("R5 rk_idx step", 128'(rk_idx), 128'(13 - j));
            chk("R4 pt_valid early", 128'(pt_valid), 128'd0);
            @(negedge clk);
        end
        chk("R4 pt_valid on time", 128'(pt_valid), 128'd1);
        chk("R2 known answer", pt, 128'h00112233445566778899aabbccddeeff);
        chk("R5 rk_idx idle", 128'(rk_idx), 128'd14);

        // R6/R7: buffered block, ignored input while busy, back-to-back restarts.
        begin
            int ib;
            ib = tail - 1;
            send_pt(rnd128());
            send_pt(rnd128());
            chk("R6 busy when buffered", 128'(busy), 128'd1);
            for (int j = 0; j < 2; j++) begin
                ct_valid = 1'b1; ct = rnd128();
                @(negedge clk);
            end
            ct_valid = 1'b0;
            chk("R6 busy held", 128'(busy), 128'd1);
            send_pt(rnd128());
            wait_drain();
            chk("R7 spacing first", 128'(pcyc[ib+1] - pcyc[ib]), 128'd15);
            chk("R7 spacing second", 128'(pcyc[ib+2] - pcyc[ib+1]), 128'd15);
        end

        // R3: multi-block CBC vector.
        set_key(256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4);
        new_msg(128'h000102030405060708090a0b0c0d0e0f);
        send_ct_exp(128'hf58c4c04d6e5f1ba779eabfb5f7bfbd6, 128'h6bc1bee22e409f96e93d7e117393172a);
        send_ct_exp(128'h9cfc4e967edb808d679f777bc6702c7d, 128'hae2d8a571e03ac9c9eb76fac45af8e51);
        send_pt(rnd128());
        wait_drain();
        chk("R3 vector drained", 128'(head), 128'(tail - 1));

        // R8: load while running is ignored; a later accepted load restarts the chain.
        send_pt(rnd128());
        iv_load = 1'b1; iv = rnd128();
        @(negedge clk);
        iv_load = 1'b0;
        send_pt(rnd128());
        wait_drain();
        chk("R8 ignored load kept parked block", 128'(head), 128'(tail - 1));
        new_msg(rnd128());
        send_pt(rnd128());
        send_pt(rnd128());
        wait_drain();
        chk("R8 new message drained", 128'(head), 128'(tail - 1));

        // R3/R9: seeded random messages with random gaps.
        for (int m = 0; m < 6; m++) begin
            int nb;
            set_key({rnd128(), rnd128()});
            new_msg(rnd128());
            nb = 1 + int'($urandom % 4);
            for (int b = 0; b < nb; b++) begin
                int gap;
                gap = int'($urandom % 20);
                repeat (gap) @(negedge clk);
                send_pt(rnd128());
            end
            send_pt(rnd128());
            wait_drain();
            chk("R9 one strobe per block", 128'(head), 128'(tail - 1));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R4 watchdog got running exp finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule